// File: doc/BRIEF.md
# Masked Interrupt Latch Controller

This controller sits beside a processor core and gathers up to 32 interrupt lines into one request. Each line has a pending bit and an enable bit. A pending bit is set by hardware when its line fires. The request is raised when at least one line is both pending and enabled, and only while the core's own interrupt-enable flag is high. Software reaches the two registers through a plain synchronous port. Address 0 selects the enable (mask) register and address 1 selects the pending (status) register. Every bit position stands for the line with the same index.

Each line is built either as an edge line or as a level line, chosen by a bit map. A build-time switch picks how pending bits are cleared. In clear-on-one mode, writing 1 to a status bit clears it; a level line's status bit then simply follows its input. In clear-on-zero mode, writing 0 clears a bit and writing 1 leaves it alone; level lines are latched in the same way as edges and must be cleared explicitly. A second output reports the lowest-numbered line that is pending and enabled, which is the order in which software services the lines.

The block has no data stream, so it has no valid/ready pairs. All pins are plain control and status. The register port accepts a write on every cycle and never stalls the core.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mask register, every status bit, `irq`, `pend_vld` and `pend_idx` are all zero.
- R2: A write with `reg_addr`=0 replaces the whole mask at the next clock edge, and a read at address 0 returns it. A write to address 1 leaves the mask unchanged.
- R3: An edge line (its bit in `LEVEL_MAP` is 0) sets its status bit at the first clock edge where its input is high after being low at the previous edge. The bit stays set after the input falls, until software clears it.
- R4: With `CLR_ON_ONE`=1, a write with `reg_addr`=1 clears each latched status bit whose data bit is 1 and keeps each bit whose data bit is 0.
- R5: With `CLR_ON_ONE`=0, a status write clears each latched bit whose data bit is 0 and keeps each bit whose data bit is 1.
- R6: With `CLR_ON_ONE`=0, a level line (its bit in `LEVEL_MAP` is 1) sets its status bit at every clock edge where its input is high. The bit stays set after the input falls, until it is cleared by a write.
- R7: With `CLR_ON_ONE`=1, a level line's status bit equals its input as sampled at the last clock edge, and status writes have no effect on it.
- R8: If a status bit is set and cleared in the same cycle, the set wins and the bit reads 1.
- R9: `irq` is registered. One clock edge after the inputs are seen, it equals `gie` AND the OR over all lines of (status AND mask).
- R10: A masked line still latches its status bit and keeps it, while contributing nothing to `irq`.
- R11: `pend_vld` and `pend_idx` are registered. One edge later they give whether any line is both pending and enabled, and the lowest index of such a line. They do not depend on `gie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | N_LINES | Interrupt lines, synchronous to clk |
| gie | input | 1 | Core-level interrupt enable |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Read data of the selected register (combinational) |
| irq | output | 1 | Registered interrupt request to the core |
| pend_vld | output | 1 | Registered: some line is pending and enabled |
| pend_idx | output | $clog2(N_LINES) | Registered lowest pending enabled line |

## Verification
Status and mask changes appear on `reg_rdata` right after the clock edge that samples the line or the write. `irq`, `pend_vld` and `pend_idx` follow one edge later, because they are computed from the register contents before that edge. The bench drives every input on the falling edge and keeps a model of both registers that it advances on each rising edge. It then compares all outputs on the next falling edge. This places each result exactly in the cycle the requirements give. Two instances, one for each clear polarity, receive the same stimulus, so one run covers both modes.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic [0:0] {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch #(
  parameter bit IS_LEVEL   = 1'b0,
  parameter bit CLR_ON_ONE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic stat_o
);
  logic in_q;
  logic set_c;
  logic clr_c;
  logic nxt_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= line_i;
  end

  always_comb begin
    clr_c = wr_i && (CLR_ON_ONE ? wbit_i : !wbit_i);
    if (IS_LEVEL) set_c = line_i;
    else          set_c = line_i && !in_q;
    if (IS_LEVEL && CLR_ON_ONE) nxt_c = line_i;          // transparent level line
    else                        nxt_c = set_c || (stat_o && !clr_c); // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= 1'b0;
    else        stat_o <= nxt_c;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES    = 32,
  parameter bit                 CLR_ON_ONE = 1'b1,
  parameter logic [N_LINES-1:0] LEVEL_MAP  = 32'h0000_FFFF,
  localparam int                IDX_W      = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic               gie,
  input  logic               reg_wen,
  input  logic               reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq,
  output logic               pend_vld,
  output logic [IDX_W-1:0]   pend_idx
);
  reg_sel_e           sel;
  logic               stat_wr;
  logic               mask_wr;
  logic [N_LINES-1:0] stat_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] live_c;
  logic               pick_vld;
  logic [IDX_W-1:0]   pick_idx;

  assign sel     = reg_sel_e'(reg_addr);
  assign stat_wr = reg_wen && (sel == SEL_STAT);
  assign mask_wr = reg_wen && (sel == SEL_MASK);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_latch #(
      .IS_LEVEL  (LEVEL_MAP[g]),
      .CLR_ON_ONE(CLR_ON_ONE)
    ) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(line_in[g]),
      .wr_i  (stat_wr),
      .wbit_i(reg_wdata[g]),
      .stat_o(stat_q[g])
    );
  end

  irq_mask_reg #(.N_LINES(N_LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mask_wr),
    .wdata_i(reg_wdata),
    .mask_o (mask_q)
  );

  assign live_c = stat_q & mask_q;

  irq_lowest_pick #(.N_LINES(N_LINES)) u_pick (
    .vec_i(live_c),
    .vld_o(pick_vld),
    .idx_o(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      pend_vld <= 1'b0;
      pend_idx <= '0;
    end else begin
      irq      <= gie && pick_vld;
      pend_vld <= pick_vld;
      pend_idx <= pick_idx;
    end
  end

  assign reg_rdata = (sel == SEL_STAT) ? stat_q : mask_q;
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int                 N_LINES   = 32,
  parameter logic [N_LINES-1:0] LEVEL_MAP = 32'h0000_FFFF
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] line_in,
  input logic               gie,
  input logic               reg_wen,
  input logic               reg_addr,
  input logic [N_LINES-1:0] reg_wdata,
  input logic               irq,
  input logic               pend_vld,
  input logic [N_LINES-1:0] stat_q,
  input logic [N_LINES-1:0] mask_q
);
  // R2: mask takes the written word
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && !reg_addr) |=> (mask_q == $past(reg_wdata)));

  // R2: mask holds without a mask write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && !reg_addr) |=> $stable(mask_q));

  // R9: registered request
  p_irq_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(gie) && (|($past(stat_q & mask_q))))));

  // R11: valid flag follows pending enabled lines
  p_pend_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_vld == (|($past(stat_q & mask_q)))));

  for (genvar g = 0; g < N_LINES; g++) begin : g_prop
    if (LEVEL_MAP[g]) begin : g_lvl
      // R6 / R7: a high level line reads pending after the edge
      p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_in[g] |=> stat_q[g]);
    end else begin : g_edge
      // R3 / R8: a rising edge always sets, even against a clear
      p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_in[g]) |=> stat_q[g]);
    end
  end
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .N_LINES  (N_LINES),
  .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_in  (line_in),
  .gie      (gie),
  .reg_wen  (reg_wen),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq      (irq),
  .pend_vld (pend_vld),
  .stat_q   (stat_q),
  .mask_q   (mask_q)
);

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] LVL        = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_in = '0;
  logic        gie = 1'b0;
  logic        reg_wen = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;

  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq, a_vld, b_vld;
  logic [4:0]  a_idx, b_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_mask = '0, m_inq = '0, ma_stat = '0, mb_stat = '0;
  logic        ma_irq = 1'b0, mb_irq = 1'b0, ma_vld = 1'b0, mb_vld = 1'b0;
  logic [4:0]  ma_idx = '0, mb_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_ctrl #(.N_LINES(32), .CLR_ON_ONE(1'b1), .LEVEL_MAP(LVL)) i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .gie(gie), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(a_rdata),
    .irq(a_irq), .pend_vld(a_vld), .pend_idx(a_idx));

  irq_latch_ctrl #(.N_LINES(32), .CLR_ON_ONE(1'b0), .LEVEL_MAP(LVL)) i_irq_latch_ctrl_w0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .gie(gie), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(b_rdata),
    .irq(b_irq), .pend_vld(b_vld), .pend_idx(b_idx));

  function automatic logic [31:0] nxt_stat(input logic [31:0] st, input logic [31:0] inq,
                                           input logic [31:0] inp, input logic wr,
                                           input logic [31:0] wd, input bit one);
    logic [31:0] clr, set, n;
    clr = wr ? (one ? wd : ~wd) : 32'h0;
    set = ((inp & ~inq) & ~LVL) | (inp & LVL);
    n   = set | (st & ~clr);
    if (one) n = (n & ~LVL) | (inp & LVL);
    return n;
  endfunction

  function automatic logic [5:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) begin
      if (v[i]) return {1'b1, 5'(i)};
    end
    return 6'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, advance one rising edge, compare
  task automatic step(input logic [31:0] lin, input logic wen, input logic adr,
                      input logic [31:0] wd, input logic g, input string tag_a,
                      input string tag_b);
    logic [31:0] na, nb, nm;
    logic [5:0]  pa, pb;
    line_in = lin; reg_wen = wen; reg_addr = adr; reg_wdata = wd; gie = g;
    na = nxt_stat(ma_stat, m_inq, lin, wen && adr, wd, 1'b1);
    nb = nxt_stat(mb_stat, m_inq, lin, wen && adr, wd, 1'b0);
    nm = (wen && !adr) ? wd : m_mask;
    pa = lowest(ma_stat & m_mask);
    pb = lowest(mb_stat & m_mask);
    @(posedge clk);
    @(negedge clk);
    ma_irq = g && pa[5]; mb_irq = g && pb[5];
    ma_vld = pa[5]; ma_idx = pa[4:0];
    mb_vld = pb[5]; mb_idx = pb[4:0];
    ma_stat = na; mb_stat = nb; m_mask = nm; m_inq = lin;
    chk(adr ? tag_a : "R2", a_rdata, adr ? ma_stat : m_mask);
    chk(adr ? tag_b : "R2", b_rdata, adr ? mb_stat : m_mask);
    chk("R9", {31'd0, a_irq}, {31'd0, ma_irq});
    chk("R9", {31'd0, b_irq}, {31'd0, mb_irq});
    chk("R11", {26'd0, a_vld, a_idx}, {26'd0, ma_vld, ma_vld ? ma_idx : 5'd0});
    chk("R11", {26'd0, b_vld, b_idx}, {26'd0, mb_vld, mb_vld ? mb_idx : 5'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    reg_addr = 1'b0; #1;
    chk("R1", a_rdata, 32'h0); chk("R1", b_rdata, 32'h0);
    reg_addr = 1'b1; #1;
    chk("R1", a_rdata, 32'h0); chk("R1", b_rdata, 32'h0);
    chk("R1", {29'd0, a_irq, a_vld, b_irq}, 32'h0);
    @(negedge clk);

    step(32'h0, 1'b1, 1'b0, 32'h0000_0005, 1'b0, "R2", "R2");
    chk("R2", a_rdata, 32'h0000_0005);
    // R3: edge line 20
    step(32'h1 << 20, 1'b0, 1'b1, 32'h0, 1'b1, "R3", "R3");
    chk("R3", {31'd0, a_rdata[20]}, 32'd1);
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R3", "R3");
    chk("R3", {31'd0, a_rdata[20]}, 32'd1);
    // R4 / R5: clear polarity
    step(32'h0, 1'b1, 1'b1, 32'h1 << 20, 1'b1, "R4", "R5");
    chk("R4", {31'd0, a_rdata[20]}, 32'd0);
    chk("R5", {31'd0, b_rdata[20]}, 32'd1);
    step(32'h0, 1'b1, 1'b1, ~(32'h1 << 20), 1'b1, "R4", "R5");
    chk("R5", {31'd0, b_rdata[20]}, 32'd0);
    // R6 / R7: level line 3
    step(32'h1 << 3, 1'b0, 1'b1, 32'h0, 1'b1, "R7", "R6");
    chk("R6", {31'd0, b_rdata[3]}, 32'd1);
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R7", "R6");
    chk("R7", {31'd0, a_rdata[3]}, 32'd0);
    chk("R6", {31'd0, b_rdata[3]}, 32'd1);
    step(32'h1 << 3, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, "R7", "R5");
    chk("R7", {31'd0, a_rdata[3]}, 32'd1);
    step(32'h0, 1'b1, 1'b1, 32'h0, 1'b1, "R7", "R5");
    chk("R5", {31'd0, b_rdata[3]}, 32'd0);
    // R8: set beats clear
    step(32'h1 << 25, 1'b1, 1'b1, 32'h1 << 25, 1'b1, "R8", "R8");
    chk("R8", {31'd0, a_rdata[25]}, 32'd1);
    step(32'h1 << 26, 1'b1, 1'b1, ~(32'h1 << 26), 1'b1, "R8", "R8");
    chk("R8", {31'd0, b_rdata[26]}, 32'd1);
    chk("R8", {31'd0, a_rdata[26]}, 32'd1);
    // R10: masked line keeps state, no request
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R10", "R10");
    chk("R10", {31'd0, a_rdata[26]}, 32'd1);
    chk("R10", {31'd0, a_irq}, 32'd0);
    // R9: unmask, request one edge later
    step(32'h0, 1'b1, 1'b0, 32'h1 << 26, 1'b1, "R2", "R2");
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R9", "R9");
    chk("R9", {31'd0, a_irq}, 32'd1);
    chk("R11", {27'd0, a_idx}, 32'd26);
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b0, "R9", "R9");
    chk("R9", {31'd0, a_irq}, 32'd0);
    chk("R11", {31'd0, a_vld}, 32'd1);
    // R11: lower index wins
    step(32'h0, 1'b1, 1'b0, (32'h1 << 26) | (32'h1 << 2), 1'b1, "R2", "R2");
    step(32'h1 << 2, 1'b0, 1'b1, 32'h0, 1'b1, "R11", "R11");
    step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R11", "R11");
    chk("R11", {27'd0, a_idx}, 32'd2);
    chk("R11", {27'd0, b_idx}, 32'd2);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] lin, wd;
      logic        wen, adr, g;
      lin = $urandom() & $urandom() & $urandom();
      wd  = $urandom();
      wen = ($urandom() % 4) == 0;
      adr = $urandom() % 2;
      g   = ($urandom() % 4) != 0;
      step(lin, wen, adr, wd, g, "R4", "R5");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule